// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one 8-bit compare channel that sits beside a free-running timer counter. It holds an active compare value. It compares that value with the counter on every timer tick. On a hit it raises a sticky compare flag and moves a waveform pin. The pin is set, cleared or toggled, depending on a two-bit output action field. The counter, its prescaler, interrupt routing and pin multiplexing all live outside the block.

The processor writes the compare value in one of two ways. In the non-PWM waveform modes, a write reaches the active register at once. In the PWM modes, a write lands in a shadow register. The active register is then reloaded from the shadow at the top or the bottom of the count, so a PWM period never sees a half-updated threshold. A force strobe, honoured only outside PWM, moves the pin as a hit would. It leaves the flag and the match strobe untouched. A counter write suppresses the compare on the first tick that follows it, so firmware can preload the counter with the compare value without an immediate hit. A clear-on-compare timer controller listens to the unregistered match strobe.

Top module: `ocu_channel`

## Requirements
- R1: After reset, cmp_active, flag, wave_out and match_strobe are all zero, and no blocking is pending.
- R2: With wave_mode[1]=0 (modes 00 normal, 01 clear-on-compare), a cmp_wr loads cmp_wdata into cmp_active at that clock edge.
- R3: With wave_mode[1]=1, a cmp_wr only fills the shadow register. cmp_active takes the shadow value at an edge where tick is high together with at_bottom (mode 10) or at_top (mode 11). It is stable otherwise. A shadow loaded in the same cycle as the reload becomes active at the next reload.
- R4: match_strobe is high in a cycle exactly when tick is high, cnt equals cmp_active, and no block applies. The flag is set at that edge and stays set.
- R5: flag_clr clears the flag at the edge. If a hit occurs in the same cycle, the set wins.
- R6: On a hit, com_mode 01 toggles the pin, 10 clears it and 11 sets it. wave_out shows the new level after that edge.
- R7: With com_mode 00, wave_out is held low.
- R8: In modes 00 and 01, force_pulse moves the pin as in R6. It does not raise match_strobe or set the flag.
- R9: In modes 10 and 11, force_pulse has no effect on the pin.
- R10: A cnt_wr blocks a hit in its own cycle. It also blocks the first tick after it, even when ticks are stopped for many cycles in between.
- R11: A force and a real hit in the same cycle apply the output action only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; the counter advances after this cycle |
| cnt | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | 00 normal, 01 clear-on-compare, 10 PWM reload at bottom, 11 PWM reload at top |
| com_mode | input | 2 | Pin action: 00 off, 01 toggle, 10 clear, 11 set |
| cmp_wr | input | 1 | Processor write of compare value |
| cmp_wdata | input | 8 | Compare write data |
| force_pulse | input | 1 | Forced compare request |
| cnt_wr | input | 1 | Processor wrote the counter this cycle |
| flag_clr | input | 1 | Write-one-to-clear of the compare flag |
| cmp_active | output | 8 | Active compare value |
| flag | output | 1 | Compare flag (interrupt request) |
| match_strobe | output | 1 | Unregistered hit indication for the counter controller |
| wave_out | output | 1 | Waveform pin |

## Verification
match_strobe depends only on the inputs and on the current state, so it is due in the same cycle as its stimulus. The bench samples it 1 ns after the inputs change, before the edge. cmp_active, flag and wave_out are registered and are due one edge later. The bench samples them 1 ns after that edge, against a model advanced by exactly one step. Blocking is checked across runs of stopped ticks, where the effect lands many cycles after the counter write.

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   com_mode,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         force_pulse,
  input  logic         cnt_wr,
  input  logic         flag_clr,
  output logic [W-1:0] cmp_active,
  output logic         flag,
  output logic         match_strobe,
  output logic         wave_out
);
  logic [W-1:0] shadow_q;
  logic         blk_q, pin_q;

  logic pwm, reload, blocked, force_hit, act;
  assign pwm          = wave_mode[1];
  assign reload       = pwm & tick & (wave_mode[0] ? at_top : at_bottom);
  assign blocked      = cnt_wr | blk_q;
  assign match_strobe = tick & (cnt == cmp_active) & ~blocked;
  assign force_hit    = force_pulse & ~pwm;
  assign act          = match_strobe | force_hit;
  assign wave_out     = pin_q & (com_mode != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_active <= '0;
      shadow_q   <= '0;
      flag       <= 1'b0;
      blk_q      <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      if (cmp_wr) shadow_q <= cmp_wdata;
      if (cmp_wr && !pwm)  cmp_active <= cmp_wdata;
      else if (reload)     cmp_active <= shadow_q;

      if (cnt_wr)    blk_q <= ~tick;
      else if (tick) blk_q <= 1'b0;

      flag <= match_strobe | (flag & ~flag_clr);

      if (act) begin
        case (com_mode)
          2'b01:   pin_q <= ~pin_q;
          2'b10:   pin_q <= 1'b0;
          2'b11:   pin_q <= 1'b1;
          default: pin_q <= pin_q;
        endcase
      end
    end
  end
endmodule

module ocu_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic         at_top,
  input logic         at_bottom,
  input logic [1:0]   wave_mode,
  input logic [1:0]   com_mode,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic         force_pulse,
  input logic         cnt_wr,
  input logic         flag_clr,
  input logic [W-1:0] cmp_active,
  input logic         flag,
  input logic         match_strobe,
  input logic         wave_out
);
  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !wave_mode[1]) |=> (cmp_active == $past(cmp_wdata)));

  a_r3_hold_between_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode[1] && !(tick && (wave_mode[0] ? at_top : at_bottom))) |=> $stable(cmp_active));

  a_r4_flag_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match_strobe));

  a_r4_strobe_needs_equal: assert property (@(posedge clk) disable iff (!rst_n)
    match_strobe |-> (tick && cnt == cmp_active));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_strobe |=> flag);

  a_r7_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    (com_mode == 2'b00) |-> !wave_out);

  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pulse && !match_strobe && !flag_clr) |=> $stable(flag));

  a_r10_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !match_strobe);
endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) u_chk (.*);

// File: tb/ocu_channel_tb.sv
module ocu_channel_tb;
  logic clk = 0, rst_n = 0;
  logic tick = 0, at_top = 0, at_bottom = 0, cmp_wr = 0, force_pulse = 0, cnt_wr = 0, flag_clr = 0;
  logic [7:0] cnt = 0, cmp_wdata = 0;
  logic [1:0] wave_mode = 0, com_mode = 0;
  logic [7:0] cmp_active;
  logic flag, match_strobe, wave_out;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_cmp, m_sh;
  logic m_flag, m_pin, m_blk;

  always #2 clk = ~clk;

  ocu_channel u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_strobe();
    return tick && (cnt == m_cmp) && !(cnt_wr || m_blk);
  endfunction

  task automatic step();
    logic ms, fh, rl;
    #1;
    ms = exp_strobe();
    chk("R4/R10 match_strobe", match_strobe, ms);
    fh = force_pulse && !wave_mode[1];
    rl = wave_mode[1] && tick && (wave_mode[0] ? at_top : at_bottom);
    if (cmp_wr && !wave_mode[1]) m_cmp = cmp_wdata;
    else if (rl) m_cmp = m_sh;
    if (cmp_wr) m_sh = cmp_wdata;
    m_blk = cnt_wr ? !tick : (tick ? 1'b0 : m_blk);
    m_flag = ms || (m_flag && !flag_clr);
    if (ms || fh) begin
      if (com_mode == 2'b01) m_pin = !m_pin;
      else if (com_mode == 2'b10) m_pin = 1'b0;
      else if (com_mode == 2'b11) m_pin = 1'b1;
    end
    @(posedge clk); #1;
    chk("R2/R3 cmp_active", cmp_active, m_cmp);
    chk("R4/R5/R8 flag", flag, m_flag);
    chk("R6/R7/R9/R11 wave_out", wave_out, m_pin && com_mode != 0);
  endtask

  task automatic idle();
    tick = 0; at_top = 0; at_bottom = 0; cmp_wr = 0; force_pulse = 0; cnt_wr = 0; flag_clr = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cmp = 0; m_sh = 0; m_flag = 0; m_pin = 0; m_blk = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cmp_active", cmp_active, 0);
    chk("R1 flag", flag, 0);
    chk("R1 wave_out", wave_out, 0);
    chk("R1 match_strobe", match_strobe, 0);
    rst_n = 1;

    // R2 direct write, then R4/R6 hit with toggle
    wave_mode = 2'b00; com_mode = 2'b01;
    cmp_wr = 1; cmp_wdata = 8'd40; step(); idle();
    chk("R2 direct", cmp_active, 40);
    tick = 1; cnt = 40; step(); idle();
    chk("R6 toggle high", wave_out, 1);
    chk("R4 flag set", flag, 1);
    // R5 clear with simultaneous hit: set wins
    flag_clr = 1; tick = 1; cnt = 40; step(); idle();
    chk("R5 set wins", flag, 1);
    flag_clr = 1; step(); idle();
    chk("R5 cleared", flag, 0);

    // R8 force in normal mode: pin toggles, no flag
    force_pulse = 1; step(); idle();
    chk("R8 force pin", wave_out, 1);
    chk("R8 force no flag", flag, 0);
    // R11 force plus hit toggles once
    force_pulse = 1; tick = 1; cnt = 40; step(); idle();
    chk("R11 single toggle", wave_out, 0);

    // R10 counter write, ticks stopped, then first tick blocked
    flag_clr = 1; step(); idle();
    cnt_wr = 1; cnt = 40; step(); idle();
    repeat (5) step();
    tick = 1; cnt = 40; step(); idle();
    chk("R10 blocked tick", flag, 0);
    tick = 1; cnt = 40; step(); idle();
    chk("R10 released", flag, 1);

    // R3 buffered write in PWM bottom mode
    wave_mode = 2'b10; com_mode = 2'b11;
    cmp_wr = 1; cmp_wdata = 8'd99; step(); idle();
    chk("R3 not yet active", cmp_active, 40);
    tick = 1; at_top = 1; cnt = 7; step(); idle();
    chk("R3 top ignored in bottom mode", cmp_active, 40);
    tick = 1; at_bottom = 1; cnt = 0; step(); idle();
    chk("R3 reload at bottom", cmp_active, 99);
    // R9 force ignored in PWM
    com_mode = 2'b01;
    force_pulse = 1; step(); idle();
    chk("R9 force ignored", wave_out, m_pin);
    // R7 pin off
    com_mode = 2'b00; step();
    chk("R7 off low", wave_out, 0);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if ((i % 200) == 0) wave_mode = 2'($urandom);
      if ((i % 37) == 0) com_mode = 2'($urandom);
      tick = r[0] | r[1];
      cnt = r[2] ? m_cmp : 8'($urandom);
      at_top = (r[5:3] == 0);
      at_bottom = (r[8:6] == 0);
      cmp_wr = (r[11:9] == 0);
      cmp_wdata = r[4] ? m_cmp : 8'($urandom);
      force_pulse = (r[14:12] == 0);
      cnt_wr = (r[18:15] == 0);
      flag_clr = (r[21:19] == 0);
      step();
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule